// File: doc/BRIEF.md
# 1-Wire Addressed Wake Filter

This block is a small 1-Wire slave front end that keeps running while the host processor sleeps in stop mode. It watches the sampled bus line for a standard-speed reset low. It answers that reset with a presence pulse and then decodes the ROM-level command that follows, checking it against the stored 64-bit device identity. The processor wake request is raised only when the command addresses this device. In every other case the block goes back to sleep and waits for the next reset, so bus traffic meant for other devices never wakes the processor.

All timing is counted in ticks of an external strobe, nominally one per microsecond. The bus pull-down output goes to an open-drain pad. The bus input is the line level, already synchronised. After the device has been addressed, the next byte the master writes is captured and flagged as a function command. The block does not interpret that byte.

Top module: `owk_wake_filter`

## Requirements
- R1: After synchronous reset, `bus_pull`, `wake_req`, `fn_seen` are 0 and `fn_code` is 00h.
- R2: While `stop_mode` is 0, the block never pulls the bus, `wake_req` and `fn_seen` are forced to 0, and bus activity is ignored (a reset low gets no presence pulse).
- R3: With `stop_mode` at 1, a low held for at least RST_MIN ticks and then released is answered by a pull-down that starts PD_WAIT ticks after the release and lasts PD_LEN ticks.
- R4: A shorter low, such as a 48–80 tick overdrive-speed reset, gets no presence pulse.
- R5: Each time slot begins at a falling edge. A received bit is the line level SAMPLE_T ticks after that edge. A transmitted 0 holds the line low from the edge until TX_HOLD ticks after it, and a transmitted 1 leaves the line alone. All bytes and ID bits travel LSB first.
- R6: Command 55h (match) is followed by 64 ID bits. If every bit equals `dev_id`, the wake request is raised. The first differing bit sends the block to sleep, and the bus is then ignored until the next reset.
- R7: Command 33h (read) makes the block send `dev_id` in 64 read slots, bit 0 first, and raise the wake request after the last slot.
- R8: Command CCh (skip) raises the wake request right after the command byte.
- R9: Command F0h (search) runs a triplet for each ID bit, LSB first: send the bit, send its complement, then receive a direction bit. A direction bit that differs from the ID bit sends the block to sleep. Completing all 64 triplets raises the wake request.
- R10: Command A5h (resume) raises the wake request only if a resume flag is set. A successful match or search sets the flag, and any other ROM command clears it.
- R11: Commands 3Ch and 69h (the overdrive variants) and any unknown code never raise the wake request. The block sleeps until the next reset.
- R12: Once addressed, the next 8 written bits are captured into `fn_code` and `fn_seen` is set.
- R13: `wake_req` stays at 1 until `stop_mode` falls.
- R14: A reset low in the middle of any command aborts it and restarts with a presence pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one per bus time unit |
| bus_in | input | 1 | Sampled bus line level (1 = released) |
| dev_id | input | ID_W | Stored device identity |
| stop_mode | input | 1 | Host processor is in stop mode |
| bus_pull | output | 1 | Pull the bus line low |
| wake_req | output | 1 | Request to wake the host processor |
| fn_seen | output | 1 | A function command byte arrived after addressing |
| fn_code | output | 8 | The captured function command byte |

## Verification
Several properties are checked on every cycle: the bus is never pulled and no wake is held while the processor is awake, a wake request persists until stop mode ends, a slot drive never outlasts its hold window, presence and slot drives never overlap, a function byte is only flagged after a wake, and a wake can only rise out of a command-decoding state. The bench scenarios have to show that the address decisions are right for each ROM command: which bit values match, the read and search bit streams, the history of the resume flag, the rejection of the overdrive commands, and that the presence pulse and the slot bits land at the right tick offsets.

// File: rtl/owk_pkg.sv
package owk_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_PRES,
        ST_CMD,
        ST_MATCH,
        ST_READ,
        ST_SRCH,
        ST_FUNC
    } owk_state_e;

    typedef enum logic [1:0] {
        TRI_BIT,
        TRI_CMP,
        TRI_DIR
    } owk_tri_e;

    typedef struct packed {
        logic fall;       // line went low this cycle
        logic strobe;     // slot sample point reached
        logic level;      // current line level
        logic reset_evt;  // long low just released
    } owk_line_t;

    localparam logic [7:0] ROM_READ     = 8'h33;
    localparam logic [7:0] ROM_MATCH    = 8'h55;
    localparam logic [7:0] ROM_SEARCH   = 8'hF0;
    localparam logic [7:0] ROM_SKIP     = 8'hCC;
    localparam logic [7:0] ROM_OD_SKIP  = 8'h3C;
    localparam logic [7:0] ROM_OD_MATCH = 8'h69;
    localparam logic [7:0] ROM_RESUME   = 8'hA5;

    // Commands that address the device with no further bits.
    function automatic logic addr_now(input logic [7:0] code, input logic resume_ok);
        return (code == ROM_SKIP) || ((code == ROM_RESUME) && resume_ok);
    endfunction

endpackage

// File: rtl/owk_line_mon.sv
module owk_line_mon
    import owk_pkg::*;
#(
    parameter int RST_MIN  = 480,
    parameter int SAMPLE_T = 25,
    parameter int SLOT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_in,
    output owk_line_t         ev,
    output logic [SLOT_W-1:0] slot_cnt
);
    localparam int LOW_W = $clog2(RST_MIN + 1);
    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    logic             bus_q;
    logic [LOW_W-1:0] low_cnt;
    logic             fall_w;
    logic             rise_w;

    assign fall_w = bus_q && !bus_in;
    assign rise_w = !bus_q && bus_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q    <= 1'b1;
            low_cnt  <= '0;
            slot_cnt <= SLOT_MAX;
        end else begin
            bus_q <= bus_in;
            if (fall_w)
                low_cnt <= '0;
            else if (!bus_in && tick && (low_cnt < LOW_W'(RST_MIN)))
                low_cnt <= low_cnt + 1'b1;
            if (fall_w)
                slot_cnt <= '0;
            else if (tick && (slot_cnt != SLOT_MAX))
                slot_cnt <= slot_cnt + 1'b1;
        end
    end

    always_comb begin
        ev.fall      = fall_w;
        ev.level     = bus_in;
        ev.strobe    = tick && (slot_cnt == SLOT_W'(SAMPLE_T - 1));
        ev.reset_evt = rise_w && (low_cnt >= LOW_W'(RST_MIN));
    end

endmodule

// File: rtl/owk_slot_io.sv
module owk_slot_io #(
    parameter int TX_HOLD = 30,
    parameter int SLOT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              fall,
    input  logic              tx_en,
    input  logic              tx_bit,
    input  logic [SLOT_W-1:0] slot_cnt,
    output logic              drive
);
    always_ff @(posedge clk) begin
        if (rst || abort)
            drive <= 1'b0;
        else if (fall)
            drive <= tx_en && !tx_bit;
        else if (drive && (slot_cnt >= SLOT_W'(TX_HOLD)))
            drive <= 1'b0;
    end

    // R5
    hold_window_chk: assert property (@(posedge clk) disable iff (rst)
        drive |-> (slot_cnt <= SLOT_W'(TX_HOLD)));

endmodule

// File: rtl/owk_presence.sv
module owk_presence #(
    parameter int PD_WAIT = 30,
    parameter int PD_LEN  = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    input  logic abort,
    output logic pull,
    output logic done
);
    localparam int CW = $clog2(((PD_WAIT > PD_LEN) ? PD_WAIT : PD_LEN) + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_PULL} ph_e;

    ph_e           ph;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst || abort) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else if (start) begin
            ph  <= PH_WAIT;
            cnt <= '0;
        end else if (tick) begin
            case (ph)
                PH_WAIT: begin
                    if (cnt == CW'(PD_WAIT - 1)) begin
                        ph  <= PH_PULL;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_PULL: begin
                    if (cnt == CW'(PD_LEN - 1)) begin
                        ph   <= PH_IDLE;
                        cnt  <= '0;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign pull = (ph == PH_PULL);

    // R3
    pres_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !pull);

endmodule

// File: rtl/owk_rom_fsm.sv
module owk_rom_fsm
    import owk_pkg::*;
#(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stop_mode,
    input  logic [ID_W-1:0] dev_id,
    input  owk_line_t       ev,
    input  logic            pres_done,
    output logic            tx_en,
    output logic            tx_bit,
    output logic            wake_req,
    output logic            fn_seen,
    output logic [7:0]      fn_code
);
    localparam int IDX_W = (ID_W > 8) ? $clog2(ID_W) : 3;
    localparam logic [IDX_W-1:0] LAST_ID  = IDX_W'(ID_W - 1);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(7);

    owk_state_e       state;
    owk_tri_e         tri_ph;
    logic [IDX_W-1:0] idx;
    logic [7:0]       shreg;
    logic             resume_q;
    logic [7:0]       rx_byte;
    logic             id_bit;

    assign rx_byte = {ev.level, shreg[7:1]};
    assign id_bit  = dev_id[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_SLEEP;
            tri_ph   <= TRI_BIT;
            idx      <= '0;
            shreg    <= '0;
            resume_q <= 1'b0;
            wake_req <= 1'b0;
            fn_seen  <= 1'b0;
            fn_code  <= '0;
        end else if (!stop_mode) begin
            state    <= ST_SLEEP;
            wake_req <= 1'b0;
            fn_seen  <= 1'b0;
            fn_code  <= '0;
        end else if (ev.reset_evt) begin
            state <= ST_PRES;
            idx   <= '0;
        end else begin
            case (state)
                ST_PRES: if (pres_done) begin
                    state <= ST_CMD;
                    idx   <= '0;
                end
                ST_CMD: if (ev.strobe) begin
                    shreg <= rx_byte;
                    if (idx == LAST_BIT) begin
                        idx    <= '0;
                        tri_ph <= TRI_BIT;
                        if (rx_byte != ROM_RESUME)
                            resume_q <= 1'b0;
                        if (addr_now(rx_byte, resume_q)) begin
                            wake_req <= 1'b1;
                            state    <= ST_FUNC;
                        end else begin
                            case (rx_byte)
                                ROM_MATCH:  state <= ST_MATCH;
                                ROM_READ:   state <= ST_READ;
                                ROM_SEARCH: state <= ST_SRCH;
                                default:    state <= ST_SLEEP;
                            endcase
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_MATCH: if (ev.strobe) begin
                    if (ev.level != id_bit) begin
                        state <= ST_SLEEP;
                    end else if (idx == LAST_ID) begin
                        wake_req <= 1'b1;
                        resume_q <= 1'b1;
                        idx      <= '0;
                        state    <= ST_FUNC;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_READ: if (ev.strobe) begin
                    if (idx == LAST_ID) begin
                        wake_req <= 1'b1;
                        idx      <= '0;
                        state    <= ST_FUNC;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_SRCH: if (ev.strobe) begin
                    case (tri_ph)
                        TRI_BIT: tri_ph <= TRI_CMP;
                        TRI_CMP: tri_ph <= TRI_DIR;
                        default: begin
                            tri_ph <= TRI_BIT;
                            if (ev.level != id_bit) begin
                                state <= ST_SLEEP;
                            end else if (idx == LAST_ID) begin
                                wake_req <= 1'b1;
                                resume_q <= 1'b1;
                                idx      <= '0;
                                state    <= ST_FUNC;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end
                    endcase
                end
                ST_FUNC: if (ev.strobe) begin
                    shreg <= rx_byte;
                    if (idx == LAST_BIT) begin
                        fn_code <= rx_byte;
                        fn_seen <= 1'b1;
                        state   <= ST_SLEEP;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tx_en  = 1'b0;
        tx_bit = 1'b1;
        if (state == ST_READ) begin
            tx_en  = 1'b1;
            tx_bit = id_bit;
        end else if (state == ST_SRCH && tri_ph != TRI_DIR) begin
            tx_en  = 1'b1;
            tx_bit = (tri_ph == TRI_BIT) ? id_bit : !id_bit;
        end
    end

    // R12
    fn_after_wake_chk: assert property (@(posedge clk) disable iff (rst)
        fn_seen |-> wake_req);

    // R13
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_req && stop_mode) |=> wake_req);

    // R6
    wake_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_req) |-> ($past(state) inside {ST_CMD, ST_MATCH, ST_READ, ST_SRCH}));

endmodule

// File: rtl/owk_wake_filter.sv
module owk_wake_filter
    import owk_pkg::*;
#(
    parameter int ID_W     = 64,
    parameter int RST_MIN  = 480,
    parameter int SAMPLE_T = 25,
    parameter int TX_HOLD  = 30,
    parameter int PD_WAIT  = 30,
    parameter int PD_LEN   = 120
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            bus_in,
    input  logic [ID_W-1:0] dev_id,
    input  logic            stop_mode,
    output logic            bus_pull,
    output logic            wake_req,
    output logic            fn_seen,
    output logic [7:0]      fn_code
);
    localparam int SLOT_W = $clog2(((SAMPLE_T > TX_HOLD) ? SAMPLE_T : TX_HOLD) + 2) + 1;

    owk_line_t         ev;
    logic [SLOT_W-1:0] slot_cnt;
    logic              tx_en;
    logic              tx_bit;
    logic              slot_drive;
    logic              pres_pull;
    logic              pres_done;

    owk_line_mon #(.RST_MIN(RST_MIN), .SAMPLE_T(SAMPLE_T), .SLOT_W(SLOT_W)) u_mon (
        .clk(clk), .rst(rst), .tick(tick), .bus_in(bus_in),
        .ev(ev), .slot_cnt(slot_cnt)
    );

    owk_presence #(.PD_WAIT(PD_WAIT), .PD_LEN(PD_LEN)) u_pres (
        .clk(clk), .rst(rst), .tick(tick),
        .start(ev.reset_evt && stop_mode), .abort(!stop_mode),
        .pull(pres_pull), .done(pres_done)
    );

    owk_slot_io #(.TX_HOLD(TX_HOLD), .SLOT_W(SLOT_W)) u_slot (
        .clk(clk), .rst(rst), .abort(!stop_mode || ev.reset_evt),
        .fall(ev.fall), .tx_en(tx_en), .tx_bit(tx_bit),
        .slot_cnt(slot_cnt), .drive(slot_drive)
    );

    owk_rom_fsm #(.ID_W(ID_W)) u_fsm (
        .clk(clk), .rst(rst), .stop_mode(stop_mode), .dev_id(dev_id),
        .ev(ev), .pres_done(pres_done),
        .tx_en(tx_en), .tx_bit(tx_bit),
        .wake_req(wake_req), .fn_seen(fn_seen), .fn_code(fn_code)
    );

    assign bus_pull = slot_drive || pres_pull;

    // R2
    awake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !stop_mode |=> (!wake_req && !bus_pull && !fn_seen));

    // R3
    drive_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(pres_pull && slot_drive));

endmodule

// File: tb/tb_owk_wake_filter.sv
`timescale 1ns/1ps
module tb_owk_wake_filter;

    localparam logic [63:0] ID = 64'hA5C3_0F96_1E2D_7B48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        stop_mode = 1'b0;
    logic        m_low = 1'b0;
    logic        bus_in;
    logic        bus_pull;
    logic        wake_req;
    logic        fn_seen;
    logic [7:0]  fn_code;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    assign bus_in = ~(m_low | bus_pull);

    owk_wake_filter dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_in(bus_in), .dev_id(ID),
        .stop_mode(stop_mode), .bus_pull(bus_pull), .wake_req(wake_req),
        .fn_seen(fn_seen), .fn_code(fn_code)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ow_reset(input int len, output logic pres);
        m_low = 1'b1;
        wait_cyc(len);
        m_low = 1'b0;
        wait_cyc(70);
        pres = !bus_in;
        wait_cyc(410);
    endtask

    task automatic write_bit(input logic b);
        m_low = 1'b1;
        wait_cyc(b ? 6 : 60);
        m_low = 1'b0;
        wait_cyc(b ? 64 : 10);
    endtask

    task automatic write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    task automatic read_bit(output logic b);
        m_low = 1'b1;
        wait_cyc(2);
        m_low = 1'b0;
        wait_cyc(10);
        b = bus_in;
        wait_cyc(58);
    endtask

    task automatic cycle_stop();
        stop_mode = 1'b0;
        wait_cyc(3);
        stop_mode = 1'b1;
        wait_cyc(3);
    endtask

    task automatic t_reset_state();
        chk("R1 bus_pull", bus_pull, 0);
        chk("R1 wake_req", wake_req, 0);
        chk("R1 fn_seen", fn_seen, 0);
        chk("R1 fn_code", fn_code, 0);
    endtask

    task automatic t_awake_ignored();
        logic p;
        stop_mode = 1'b0;
        ow_reset(500, p);
        chk("R2 no presence when awake", p, 0);
        write_byte(8'hCC);
        chk("R2 no wake when awake", wake_req, 0);
    endtask

    task automatic t_presence();
        logic p;
        stop_mode = 1'b1;
        wait_cyc(3);
        ow_reset(70, p);
        chk("R4 overdrive reset ignored", p, 0);
        // R3 timing probe: line still free just after release, low mid-window, free after
        m_low = 1'b1;
        wait_cyc(500);
        m_low = 1'b0;
        wait_cyc(20);
        chk("R3 wait before presence", bus_in, 1);
        wait_cyc(50);
        chk("R3 presence low", bus_in, 0);
        wait_cyc(100);
        chk("R3 presence ended", bus_in, 1);
        wait_cyc(310);
    endtask

    task automatic t_match_ok();
        logic p;
        ow_reset(500, p);
        write_byte(8'h55);
        for (int i = 0; i < 64; i++) write_bit(ID[i]);
        chk("R6 match wakes", wake_req, 1);
        write_byte(8'h96);
        chk("R12 fn_seen", fn_seen, 1);
        chk("R12 fn_code", fn_code, 8'h96);
        wait_cyc(300);
        chk("R13 wake held", wake_req, 1);
        stop_mode = 1'b0;
        wait_cyc(3);
        chk("R2 wake cleared", wake_req, 0);
        chk("R2 fn cleared", fn_seen, 0);
        stop_mode = 1'b1;
        wait_cyc(3);
    endtask

    task automatic t_match_bad();
        logic p;
        logic [63:0] bad;
        bad = ID ^ (64'd1 << 40);
        ow_reset(500, p);
        write_byte(8'h55);
        for (int i = 0; i < 64; i++) write_bit(bad[i]);
        chk("R6 mismatch no wake", wake_req, 0);
        write_byte(8'h11);
        chk("R6 bus ignored after mismatch", fn_seen, 0);
    endtask

    task automatic t_read();
        logic p;
        logic b;
        logic [63:0] got;
        ow_reset(500, p);
        write_byte(8'h33);
        // R5: bit 0 of ID is 0; line low at 12 ticks, free again at 45
        m_low = 1'b1;
        wait_cyc(2);
        m_low = 1'b0;
        wait_cyc(10);
        chk("R5 tx zero held", bus_in, 0);
        wait_cyc(33);
        chk("R5 tx zero released", bus_in, 1);
        wait_cyc(25);
        got = '0;
        for (int i = 1; i < 64; i++) begin
            read_bit(b);
            got[i] = b;
        end
        chk("R7 read id", got, ID);
        chk("R7 read wakes", wake_req, 1);
        cycle_stop();
    endtask

    task automatic t_skip();
        logic p;
        ow_reset(500, p);
        write_byte(8'hCC);
        chk("R8 skip wakes", wake_req, 1);
        cycle_stop();
    endtask

    task automatic t_search(input int bad_at);
        logic p;
        logic b;
        logic c;
        logic [63:0] gb;
        logic [63:0] gc;
        gb = '0;
        gc = '0;
        ow_reset(500, p);
        write_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            read_bit(b);
            read_bit(c);
            gb[i] = b;
            gc[i] = c;
            if (i == bad_at) begin
                write_bit(!ID[i]);
                read_bit(b);
                chk("R9 ignored after wrong direction", b, 1);
                chk("R9 wrong direction no wake", wake_req, 0);
                break;
            end
            write_bit(ID[i]);
        end
        if (bad_at >= 64) begin
            chk("R9 search bits", gb, ID);
            chk("R9 search complements", gc, ~ID);
            chk("R9 search wakes", wake_req, 1);
            cycle_stop();
        end
    endtask

    task automatic t_resume();
        logic p;
        ow_reset(500, p);
        write_byte(8'hA5);
        chk("R10 resume after search", wake_req, 1);
        cycle_stop();
        ow_reset(500, p);
        write_byte(8'hCC);
        cycle_stop();
        ow_reset(500, p);
        write_byte(8'hA5);
        chk("R10 resume after skip", wake_req, 0);
    endtask

    task automatic t_overdrive();
        logic p;
        ow_reset(500, p);
        write_byte(8'h3C);
        chk("R11 od-skip no wake", wake_req, 0);
        write_byte(8'h22);
        chk("R11 od-skip then ignored", fn_seen, 0);
        ow_reset(500, p);
        write_byte(8'h69);
        for (int i = 0; i < 64; i++) write_bit(ID[i]);
        chk("R11 od-match no wake", wake_req, 0);
    endtask

    task automatic t_abort();
        logic p;
        ow_reset(500, p);
        for (int i = 0; i < 4; i++) write_bit(i[0]);
        ow_reset(500, p);
        chk("R14 presence on mid-command reset", p, 1);
        write_byte(8'hCC);
        chk("R14 fresh command decoded", wake_req, 1);
        cycle_stop();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        t_reset_state();
        t_awake_ignored();
        t_presence();
        t_match_ok();
        t_match_bad();
        t_read();
        t_skip();
        t_search(10);
        t_search(64);
        t_resume();
        t_overdrive();
        t_abort();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule